// File: doc/BRIEF.md
# ISA I/O Index/Data Port Decoder

This block decodes 8-bit I/O cycles on a 10-bit ISA port space for a peripheral that exposes an index port and a data port at a jumper-selected base. Address decoding happens in two stages. The top address bits choose one of two groups. A one-of-eight decoder then uses the next three bits to pick a block. The block chosen by the base-select input becomes the active-low "hit" signal. From hit, the low address bits and the IOR/IOW strobes, a purely combinational stage forms an index-write strobe, a data-write strobe, a data-read strobe and the direction control for the data transceiver.

A small state machine holds IORDY low for a fixed number of bus clocks during data-port cycles when wait states are enabled. A behavioural index register and an 8-entry register file sit behind the strobes, so the whole path can be exercised end to end. A host first writes a register number to the index port (base+0). It then reads or writes that register through the data port (base+2).

The wait controller has three states. WT_IDLE means no wait is in progress. WT_COUNT means IORDY is held low while a counter runs. WT_RELEASE means the terminal count has been reached and IORDY is released. The transitions are:
- **start_wait**: WT_IDLE to WT_COUNT, when a data-port cycle occurs with wait_en high.
- **terminal**: WT_COUNT to WT_RELEASE, when the counter reaches WAIT_CLKS-1.
- **abort**: WT_COUNT to WT_IDLE, when both strobes go inactive.
- **cycle_end**: WT_RELEASE to WT_IDLE, when both strobes go inactive.

Top module: `isa_portpair_dec`

## Requirements
- R1: hit_n is low exactly when addr[9:8] = 2'b10 and addr[7:4] equals base_sel. addr[7] picks the group (0 for 0x200-0x27F, 1 for 0x280-0x2FF), and addr[6:4] picks one of eight blocks in that group. The default 0x2E0 corresponds to base_sel = 4'hE.
- R2: idx_wr_n is low exactly when iow_n is low, hit_n is low and addr[3:1] = 3'b000. A read at that port asserts no strobe and does not enable the data output.
- R3: dat_wr_n is low exactly when iow_n is low, hit_n is low and addr[3:1] = 3'b001.
- R4: dat_rd_n is low exactly when ior_n is low, hit_n is low and addr[3:1] = 3'b001. While it is low, d_oe is high and d_out carries the selected register.
- R5: xcvr_dir is low (peripheral to bus) only while dat_rd_n is low, and is high otherwise.
- R6: addr[0] plays no part in decoding, so an odd port aliases to the even port below it.
- R7: When hit_n is high, or when ior_n and iow_n are both high, all three strobes are high in the same combinational evaluation, with no clock involved.
- R8: During a data-port cycle with wait_en high, iordy goes low at once. It stays low across WAIT_CLKS rising clock edges (default 4) and is high after the WAIT_CLKS-th edge. With wait_en low, or on the index port, iordy stays high.
- R9: When both strobes are inactive the wait counter clears, so the next data-port cycle receives the full WAIT_CLKS wait again. iordy is high whenever no strobe is active.
- R10: On the first clock edge of an index-write strobe, d_in is latched as the selector. On the first clock edge of a data-write strobe, d_in is stored into register selector mod REG_COUNT (default 8). Data reads return that register.
- R11: After reset, all registers and the selector are zero, iordy is high, d_oe is low and all strobes are high while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 10 | I/O address A9..A0 |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| base_sel | input | 4 | Jumper base select, matched against addr[7:4] |
| wait_en | input | 1 | Wait-state request enable |
| d_in | input | 8 | Write data from the bus |
| hit_n | output | 1 | Active-low block-addressed signal |
| idx_wr_n | output | 1 | Active-low index-port write strobe |
| dat_wr_n | output | 1 | Active-low data-port write strobe |
| dat_rd_n | output | 1 | Active-low data-port read strobe |
| xcvr_dir | output | 1 | Transceiver direction, low when driving the bus |
| iordy | output | 1 | Channel ready, low while a wait is in progress |
| d_out | output | 8 | Read data toward the bus |
| d_oe | output | 1 | High while d_out should be driven |

## Verification
The hardest situation to reach from the ports is the boundary of the wait window: the exact edge where WT_COUNT hands over to WT_RELEASE. A second hard case is a new cycle that follows an aborted or completed wait, which must again receive the full count. The stimulus holds a data-port read with wait_en high and samples iordy between edges, both just before and just after the WAIT_CLKS-th edge. It then drops the strobes for one clock, starts a second data-port cycle and checks for the same full window. Register-file aliasing is reached by writing an index above REG_COUNT and reading back through an odd data-port address.

// File: rtl/isa_pp_pkg.sv
package isa_pp_pkg;
    localparam int ADDR_W = 10;

    localparam logic [2:0] IDX_PORT  = 3'b000;
    localparam logic [2:0] DATA_PORT = 3'b001;

    typedef enum logic [1:0] {
        WT_IDLE    = 2'd0,
        WT_COUNT   = 2'd1,
        WT_RELEASE = 2'd2
    } wait_state_e;
endpackage

// File: rtl/isa_blk_decode.sv
module isa_blk_decode #(
    parameter int GROUPS     = 2,
    parameter int BLK_BITS   = 3
) (
    input  logic [9:4] addr_hi,
    input  logic [3:0] base_sel,
    output logic       hit_n
);
    localparam int BLOCKS = 1 << BLK_BITS;
    localparam int OUTS   = GROUPS * BLOCKS;

    logic [GROUPS-1:0] grp_en;
    logic [OUTS-1:0]   sel_n;

    genvar g, k;
    generate
        for (g = 0; g < GROUPS; g++) begin : g_group
            // coarse stage: addr[9:8] must be 10, addr[7] names the group
            assign grp_en[g] = (addr_hi[9:8] == 2'b10) && (addr_hi[7] == g[0]);
            for (k = 0; k < BLOCKS; k++) begin : g_blk
                // fine stage: one-of-eight on addr[6:4]
                assign sel_n[g*BLOCKS + k] =
                    ~(grp_en[g] && (addr_hi[6:4] == k[BLK_BITS-1:0]));
            end
        end
    endgenerate

    // jumper routes one decoder output back as the addressed signal
    always_comb begin
        hit_n = sel_n[base_sel];
    end
endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen
    import isa_pp_pkg::*;
(
    input  logic       hit_n,
    input  logic [2:0] port_sel,
    input  logic       ior_n,
    input  logic       iow_n,
    output logic       idx_wr_n,
    output logic       dat_wr_n,
    output logic       dat_rd_n,
    output logic       xcvr_dir,
    output logic       dat_cycle,
    output logic       any_strobe
);
    logic at_idx;
    logic at_data;

    always_comb begin
        at_idx     = !hit_n && (port_sel == IDX_PORT);
        at_data    = !hit_n && (port_sel == DATA_PORT);
        any_strobe = !ior_n || !iow_n;

        idx_wr_n   = !(at_idx  && !iow_n);
        dat_wr_n   = !(at_data && !iow_n);
        dat_rd_n   = !(at_data && !ior_n);
        xcvr_dir   = dat_rd_n;
        dat_cycle  = at_data && any_strobe;
    end
endmodule

// File: rtl/isa_wait_ctl.sv
module isa_wait_ctl
    import isa_pp_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int WAIT_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dat_cycle,
    input  logic any_strobe,
    input  logic wait_en,
    output logic iordy
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CLKS - 1);

    wait_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             term;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        term    = (cnt_q == LAST);
        unique case (state_q)
            WT_IDLE: begin
                cnt_d = '0;
                if (dat_cycle && wait_en) begin      // start_wait
                    state_d = WT_COUNT;
                    cnt_d   = CNT_W'(1);
                end
            end
            WT_COUNT: begin
                if (!any_strobe) begin               // abort
                    state_d = WT_IDLE;
                    cnt_d   = '0;
                end else if (term) begin             // terminal
                    state_d = WT_RELEASE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            WT_RELEASE: begin
                if (!any_strobe) begin               // cycle_end
                    state_d = WT_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = WT_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        iordy = 1'b1;
        unique case (state_q)
            WT_IDLE:    iordy = !(dat_cycle && wait_en);
            WT_COUNT:   iordy = !dat_cycle;
            WT_RELEASE: iordy = 1'b1;
            default:    iordy = 1'b1;
        endcase
    end
endmodule

// File: rtl/isa_regfile.sv
module isa_regfile #(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr_n,
    input  logic              dat_wr_n,
    input  logic              dat_rd_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe
);
    localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    logic [DATA_W-1:0] regs [REG_COUNT];
    logic [DATA_W-1:0] index_q;
    logic              idx_prev, dat_prev;
    logic [IDX_W-1:0]  slot;

    assign slot = index_q[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q  <= '0;
            idx_prev <= 1'b1;
            dat_prev <= 1'b1;
            for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
        end else begin
            idx_prev <= idx_wr_n;
            dat_prev <= dat_wr_n;
            // act only on the first clock of each strobe
            if (!idx_wr_n && idx_prev) index_q <= d_in;
            if (!dat_wr_n && dat_prev) regs[slot] <= d_in;
        end
    end

    always_comb begin
        d_oe  = !dat_rd_n;
        d_out = d_oe ? regs[slot] : '0;
    end
endmodule

// File: rtl/isa_portpair_dec.sv
module isa_portpair_dec
    import isa_pp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 8,
    parameter int CNT_W     = 4,
    parameter int WAIT_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        addr,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic [3:0]        base_sel,
    input  logic              wait_en,
    input  logic [DATA_W-1:0] d_in,
    output logic              hit_n,
    output logic              idx_wr_n,
    output logic              dat_wr_n,
    output logic              dat_rd_n,
    output logic              xcvr_dir,
    output logic              iordy,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe
);
    logic dat_cycle;
    logic any_strobe;

    isa_blk_decode #(.GROUPS(2), .BLK_BITS(3)) u_dec (
        .addr_hi  (addr[9:4]),
        .base_sel (base_sel),
        .hit_n    (hit_n)
    );

    // addr[0] is not routed anywhere
    isa_strobe_gen u_stb (
        .hit_n      (hit_n),
        .port_sel   (addr[3:1]),
        .ior_n      (ior_n),
        .iow_n      (iow_n),
        .idx_wr_n   (idx_wr_n),
        .dat_wr_n   (dat_wr_n),
        .dat_rd_n   (dat_rd_n),
        .xcvr_dir   (xcvr_dir),
        .dat_cycle  (dat_cycle),
        .any_strobe (any_strobe)
    );

    isa_wait_ctl #(.CNT_W(CNT_W), .WAIT_CLKS(WAIT_CLKS)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .dat_cycle  (dat_cycle),
        .any_strobe (any_strobe),
        .wait_en    (wait_en),
        .iordy      (iordy)
    );

    isa_regfile #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr_n (idx_wr_n),
        .dat_wr_n (dat_wr_n),
        .dat_rd_n (dat_rd_n),
        .d_in     (d_in),
        .d_out    (d_out),
        .d_oe     (d_oe)
    );
endmodule

// File: rtl/isa_portpair_chk.sv
module isa_portpair_chk #(
    parameter int WAIT_CLKS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [9:0] addr,
    input logic       ior_n,
    input logic       iow_n,
    input logic       hit_n,
    input logic       idx_wr_n,
    input logic       dat_wr_n,
    input logic       dat_rd_n,
    input logic       xcvr_dir,
    input logic       iordy,
    input logic       d_oe
);
    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               low_run <= '0;
        else if (iordy)           low_run <= '0;
        else if (low_run != 8'hFF) low_run <= low_run + 8'd1;
    end

    // R2
    idx_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr_n |-> (!iow_n && !hit_n && addr[3:1] == 3'b000));

    // R4
    read_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> (!dat_rd_n && !ior_n));

    // R5
    dir_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_dir |-> !dat_rd_n);

    // R7
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ior_n && iow_n) |-> (idx_wr_n && dat_wr_n && dat_rd_n));

    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iordy |-> (low_run < 8'(WAIT_CLKS)));

    // R9
    ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ior_n && iow_n) |-> iordy);
endmodule

bind isa_portpair_dec isa_portpair_chk #(.WAIT_CLKS(WAIT_CLKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .hit_n    (hit_n),
    .idx_wr_n (idx_wr_n),
    .dat_wr_n (dat_wr_n),
    .dat_rd_n (dat_rd_n),
    .xcvr_dir (xcvr_dir),
    .iordy    (iordy),
    .d_oe     (d_oe)
);

// File: tb/isa_portpair_dec_test.sv
`timescale 1ns/1ps
module isa_portpair_dec_test;
    localparam int WAIT_CLKS = 4;
    localparam int NVEC = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] addr = '0;
    logic       ior_n = 1'b1;
    logic       iow_n = 1'b1;
    logic [3:0] base_sel = 4'hE;
    logic       wait_en = 1'b0;
    logic [7:0] d_in = '0;
    logic       hit_n, idx_wr_n, dat_wr_n, dat_rd_n, xcvr_dir, iordy, d_oe;
    logic [7:0] d_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    isa_portpair_dec #(.WAIT_CLKS(WAIT_CLKS)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ior_n(ior_n), .iow_n(iow_n),
        .base_sel(base_sel), .wait_en(wait_en), .d_in(d_in),
        .hit_n(hit_n), .idx_wr_n(idx_wr_n), .dat_wr_n(dat_wr_n),
        .dat_rd_n(dat_rd_n), .xcvr_dir(xcvr_dir), .iordy(iordy),
        .d_out(d_out), .d_oe(d_oe)
    );

    // {addr, ior_n, iow_n, base_sel, hit_n, idx_wr_n, dat_wr_n, dat_rd_n, xcvr_dir}
    localparam logic [20:0] VEC [NVEC] = '{
        {10'h2E0, 1'b1, 1'b0, 4'hE, 5'b0_0_1_1_1},  // R2 index write
        {10'h2E0, 1'b0, 1'b1, 4'hE, 5'b0_1_1_1_1},  // R2 index read: nothing
        {10'h2E2, 1'b1, 1'b0, 4'hE, 5'b0_1_0_1_1},  // R3 data write
        {10'h2E2, 1'b0, 1'b1, 4'hE, 5'b0_1_1_0_0},  // R4 R5 data read
        {10'h2E3, 1'b0, 1'b1, 4'hE, 5'b0_1_1_0_0},  // R6 odd alias read
        {10'h2E1, 1'b1, 1'b0, 4'hE, 5'b0_0_1_1_1},  // R6 odd alias index
        {10'h2E0, 1'b1, 1'b1, 4'hE, 5'b0_1_1_1_1},  // R7 no strobe
        {10'h3E2, 1'b0, 1'b1, 4'hE, 5'b1_1_1_1_1},  // R1 wrong A9..A8
        {10'h2F2, 1'b0, 1'b1, 4'hE, 5'b1_1_1_1_1},  // R1 wrong block
        {10'h260, 1'b1, 1'b0, 4'h6, 5'b0_0_1_1_1},  // R1 first group
        {10'h2E0, 1'b1, 1'b0, 4'h6, 5'b1_1_1_1_1},  // R1 group mismatch
        {10'h2E4, 1'b1, 1'b0, 4'hE, 5'b0_1_1_1_1},  // R7 other low bits
        {10'h0E2, 1'b0, 1'b1, 4'hE, 5'b1_1_1_1_1},  // R1 low space
        {10'h2EA, 1'b0, 1'b1, 4'hE, 5'b0_1_1_1_1}   // R7 port 0x2EA
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // one full bus cycle held for two clocks, launched and ended at negedges
    task automatic bus_cycle(input logic [9:0] a, input bit is_wr, input logic [7:0] d);
        @(negedge clk);
        addr = a; d_in = d;
        if (is_wr) iow_n = 1'b0; else ior_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        iow_n = 1'b1; ior_n = 1'b1;
    endtask

    task automatic read_check(input logic [9:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; ior_n = 1'b0;
        #1;
        chk(req, {31'd0, d_oe}, 32'd1);
        chk(req, {24'd0, d_out}, {24'd0, exp});
        @(negedge clk);
        ior_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11 iordy", {31'd0, iordy}, 32'd1);
        chk("R11 d_oe", {31'd0, d_oe}, 32'd0);
        chk("R11 strobes", {29'd0, idx_wr_n, dat_wr_n, dat_rd_n}, 32'd7);
        rst_n = 1'b1;
        @(negedge clk);
        read_check(10'h2E2, 8'h00, "R11 reg zero");

        // decode table, wait states off
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {addr, ior_n, iow_n, base_sel} = VEC[i][20:5];
            #1;
            chk($sformatf("R1 R2 R3 R4 R5 decode vec %0d", i),
                {27'd0, hit_n, idx_wr_n, dat_wr_n, dat_rd_n, xcvr_dir},
                {27'd0, VEC[i][4:0]});
        end
        @(negedge clk);
        ior_n = 1'b1; iow_n = 1'b1; base_sel = 4'hE;

        // fresh state for register tests
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R10 index then data write, read back
        bus_cycle(10'h2E0, 1'b1, 8'h03);
        bus_cycle(10'h2E2, 1'b1, 8'hA5);
        bus_cycle(10'h2E0, 1'b1, 8'h05);
        bus_cycle(10'h2E3, 1'b1, 8'h3C);     // R6 odd data address
        bus_cycle(10'h2E1, 1'b1, 8'h03);     // R6 odd index address
        read_check(10'h2E2, 8'hA5, "R10 reg3 readback");
        bus_cycle(10'h2E0, 1'b1, 8'h0D);     // 13 mod 8 = 5
        read_check(10'h2E3, 8'h3C, "R10 R6 reg5 alias");

        // R2 index port read does not enable output
        @(negedge clk);
        addr = 10'h2E0; ior_n = 1'b0;
        #1;
        chk("R2 index read d_oe", {31'd0, d_oe}, 32'd0);
        chk("R5 index read dir", {31'd0, xcvr_dir}, 32'd1);
        @(negedge clk);
        ior_n = 1'b1;

        // R8 wait window on a data-port read
        @(negedge clk);
        wait_en = 1'b1; addr = 10'h2E2; ior_n = 1'b0;
        #1;
        chk("R8 iordy low at start", {31'd0, iordy}, 32'd0);
        repeat (WAIT_CLKS - 1) @(posedge clk);
        #1;
        chk("R8 iordy low before terminal", {31'd0, iordy}, 32'd0);
        @(posedge clk);
        #1;
        chk("R8 iordy released", {31'd0, iordy}, 32'd1);
        @(negedge clk);
        ior_n = 1'b1;
        #1;
        chk("R9 iordy idle", {31'd0, iordy}, 32'd1);

        // R9 next cycle gets a full wait again
        @(negedge clk);
        addr = 10'h2E2; iow_n = 1'b0;
        repeat (WAIT_CLKS - 1) @(posedge clk);
        #1;
        chk("R9 full wait repeated", {31'd0, iordy}, 32'd0);
        @(posedge clk);
        #1;
        chk("R9 release repeated", {31'd0, iordy}, 32'd1);
        @(negedge clk);
        iow_n = 1'b1;

        // R9 aborted wait clears the counter
        @(negedge clk);
        addr = 10'h2E2; ior_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        ior_n = 1'b1;
        @(negedge clk);
        ior_n = 1'b0;
        repeat (WAIT_CLKS - 1) @(posedge clk);
        #1;
        chk("R9 wait after abort", {31'd0, iordy}, 32'd0);
        @(negedge clk);
        ior_n = 1'b1;

        // R8 no wait on the index port, nor with wait_en low
        @(negedge clk);
        addr = 10'h2E0; iow_n = 1'b0; d_in = 8'h00;
        #1;
        chk("R8 index port no wait", {31'd0, iordy}, 32'd1);
        @(negedge clk);
        iow_n = 1'b1; wait_en = 1'b0;
        @(negedge clk);
        addr = 10'h2E2; ior_n = 1'b0;
        #1;
        chk("R8 wait disabled", {31'd0, iordy}, 32'd1);
        @(negedge clk);
        ior_n = 1'b1;

        @(negedge clk);
        finish_run();
    end
endmodule